// File: doc/BRIEF.md
# Palette RAM Paired-Byte Writer

This block holds the 64-entry colour table of a video display processor and sits behind the processor's byte-wide data port. The same port also feeds a 16 KB video memory that lives outside the block. A 2-bit target code chooses where each data byte goes. When the code selects the colour table, bytes are committed in pairs. A byte sent to an even address is parked in a holding register. The byte that follows at the odd address commits both bytes at once to the two neighbouring table entries. Every other code turns the byte into a write strobe toward the external video memory.

The data port is a valid/ready stream. A byte is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. The sender must hold `wr_valid`, `wr_data` and `ctrl_code` steady until the byte is accepted. `wr_ready` is low only while the table is being cleared after reset, and the sender simply waits through that time.

The block keeps a 14-bit access address. The address moves up by one after every accepted byte, whatever its target, and `addr_set` loads a new value. A combinational read port lets the surrounding logic inspect any table entry.

Top module: `pal_pair_writer`

## Requirements
- R1: A synchronous active-high `rst` clears the address to 0 and starts a clearing sweep. `busy` is high and `wr_ready` is low for exactly 64 clock edges after `rst` is released. After that, all 64 entries read 0.
- R2: An accepted byte with `ctrl_code` = 2'b11 (the colour table code) at an even address changes no table entry.
- R3: An accepted colour-table byte at an odd address A has two effects on the same edge. Entry A−1 receives the held byte. Entry A receives the new byte with bits 7:4 forced to 0 and bits 3:0 kept.
- R4: The table index is the access address modulo 64, which is its low 6 bits.
- R5: An accepted byte with any other `ctrl_code` raises `vram_we` in that cycle. In the same cycle `vram_addr` shows the current address and `vram_data` shows the byte. No table entry changes.
- R6: Each accepted byte advances the address by one, and the address wraps from 0x3FFF to 0.
- R7: `addr_set` loads `addr_in` into the address on the next edge. This takes priority over the increment.
- R8: `rst` sets the holding register to 0. An odd-address colour write that has no even-address write before it therefore stores 0 at entry A−1.
- R9: While `busy` is high, no byte is accepted. The address stays unchanged and `vram_we` stays low.
- R10: The holding register changes only on even-address colour-table writes. Video-memory writes in between leave it intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_set | input | 1 | Load `addr_in` into the access address |
| addr_in | input | 14 | New access address |
| ctrl_code | input | 2 | Target of data bytes; 2'b11 selects the colour table |
| wr_valid | input | 1 | Data byte offered |
| wr_ready | output | 1 | Data byte can be accepted |
| wr_data | input | 8 | Data byte |
| vram_we | output | 1 | Write strobe toward the video memory |
| vram_addr | output | 14 | Current access address |
| vram_data | output | 8 | Byte for the video memory |
| rd_idx | input | 6 | Table read-back index |
| rd_data | output | 8 | Table entry at `rd_idx` |
| busy | output | 1 | Clearing sweep in progress |

## Verification
The hardest state to reach is a held byte that survives interleaved video-memory writes and address reloads until an odd-address colour write finally commits it. The hold is invisible at the ports until that commit. The directed part of the stimulus parks a byte, issues a video-memory write and a reload, and then completes the pair. The random part mixes targets, reloads to arbitrary 14-bit addresses and data values, so pairs are often split across such events. A write held pending through the whole clearing sweep is also driven, to show that it is not accepted early.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int PAL_ADDR_W  = 14;
  localparam int PAL_DATA_W  = 8;
  localparam int PAL_ENTRIES = 64;
  localparam int PAL_CODE_W  = 2;
  localparam int PAL_KEEP_W  = 4;
  localparam logic [PAL_CODE_W-1:0] PAL_WRITE_CODE = 2'b11;
endpackage

// File: rtl/pal_addr_ctr.sv
module pal_addr_ctr #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  // load has priority over step; wrap is natural modulo 2**AW
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + AW'(1);
  end
endmodule

// File: rtl/pal_pair_latch.sv
module pal_pair_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (capture) held <= din;
  end
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int DW      = 8,
  parameter int ENTRIES = 64,
  localparam int IW     = $clog2(ENTRIES),
  localparam int SW     = IW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pair_we,
  input  logic [SW-1:0] slot,
  input  logic [DW-1:0] lo_data,
  input  logic [DW-1:0] hi_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [DW-1:0] mem [ENTRIES];
  logic [IW-1:0] sweep_idx;

  // clearing sweep: one entry per cycle, busy drops with the last one
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b1;
      sweep_idx <= '0;
    end else if (busy) begin
      sweep_idx <= sweep_idx + IW'(1);
      if (sweep_idx == LAST) busy <= 1'b0;
    end
  end

  // storage has no reset; the sweep owns it until busy falls
  always_ff @(posedge clk) begin
    if (!rst) begin
      if (busy) begin
        mem[sweep_idx] <= '0;
      end else if (pair_we) begin
        mem[{slot, 1'b0}] <= lo_data;
        mem[{slot, 1'b1}] <= hi_data;
      end
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/pal_pair_writer.sv
module pal_pair_writer
  import pal_pkg::*;
#(
  parameter int AW      = PAL_ADDR_W,
  parameter int DW      = PAL_DATA_W,
  parameter int ENTRIES = PAL_ENTRIES,
  parameter int CW      = PAL_CODE_W,
  parameter int KEEP_W  = PAL_KEEP_W,
  parameter logic [CW-1:0] PAL_CODE = PAL_WRITE_CODE,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_set,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] ctrl_code,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          vram_we,
  output logic [AW-1:0] vram_addr,
  output logic [DW-1:0] vram_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam logic [DW-1:0] KEEP_MASK = DW'((1 << KEEP_W) - 1);

  logic          accept, to_pal, odd_addr, capture, pair_we;
  logic [AW-1:0] addr;
  logic [DW-1:0] held;

  assign wr_ready = ~busy;
  assign accept   = wr_valid & wr_ready;
  assign to_pal   = (ctrl_code == PAL_CODE);
  assign odd_addr = addr[0];
  assign capture  = accept & to_pal & ~odd_addr;
  assign pair_we  = accept & to_pal &  odd_addr;

  pal_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load(addr_set), .load_val(addr_in),
    .step(accept), .addr(addr)
  );

  pal_pair_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst(rst), .capture(capture), .din(wr_data), .held(held)
  );

  pal_store #(.DW(DW), .ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .pair_we(pair_we),
    .slot(addr[IW-1:1]), .lo_data(held), .hi_data(wr_data & KEEP_MASK),
    .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy)
  );

  assign vram_we   = accept & ~to_pal;
  assign vram_addr = addr;
  assign vram_data = wr_data;
endmodule

// File: rtl/pal_pair_writer_chk.sv
module pal_pair_writer_chk #(
  parameter int AW = 14,
  parameter int CW = 2,
  parameter logic [CW-1:0] PAL_CODE = 2'b11
) (
  input logic          clk,
  input logic          rst,
  input logic          addr_set,
  input logic [AW-1:0] addr_in,
  input logic [CW-1:0] ctrl_code,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          vram_we,
  input logic [AW-1:0] vram_addr,
  input logic          busy
);
  logic [7:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 8'd1;
    else           busy_run <= '0;
  end

  // R1
  sweep_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> busy_run < 8'd64);

  // R5
  vram_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    vram_we |-> (wr_valid && ctrl_code != PAL_CODE));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && !addr_set) |=> vram_addr == $past(vram_addr) + AW'(1));

  // R7
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    addr_set |=> vram_addr == $past(addr_in));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !addr_set) |=> $stable(vram_addr));
endmodule

bind pal_pair_writer pal_pair_writer_chk #(.AW(AW), .CW(CW), .PAL_CODE(PAL_CODE)) u_chk (.*);

// File: tb/pal_pair_writer_bench.sv
module pal_pair_writer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_set = 1'b0;
  logic [13:0] addr_in = '0;
  logic [1:0]  ctrl_code = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic        vram_we;
  logic [13:0] vram_addr;
  logic [7:0]  vram_data;
  logic [5:0]  rd_idx = '0;
  logic [7:0]  rd_data;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  model [64];
  logic [7:0]  m_held;
  logic [13:0] m_addr;

  always #5 clk = ~clk;

  pal_pair_writer u_pal_pair_writer (.*);

  function automatic logic [7:0] keep_low(input logic [7:0] d);
    return d & 8'h0F;
  endfunction

  function automatic logic [5:0] tbl_idx(input logic [13:0] a);
    return a[5:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_entry(input int i, input string req);
    rd_idx = 6'(i);
    #1;
    chk(rd_data === model[i], req, int'(rd_data), int'(model[i]));
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 64; i++) check_entry(i, req);
  endtask

  task automatic set_addr(input logic [13:0] a);
    @(negedge clk);
    addr_set = 1'b1;
    addr_in  = a;
    @(posedge clk);
    #1;
    addr_set = 1'b0;
    m_addr = a;
    chk(vram_addr === a, "R7", int'(vram_addr), int'(a));
  endtask

  task automatic put(input logic [1:0] code, input logic [7:0] d);
    logic [5:0] ix;
    @(negedge clk);
    ctrl_code = code;
    wr_data   = d;
    wr_valid  = 1'b1;
    #1;
    if (code != 2'b11) begin
      chk(vram_we === 1'b1 && vram_addr === m_addr && vram_data === d, "R5",
          int'({vram_we, vram_addr, vram_data}), int'({1'b1, m_addr, d}));
    end else begin
      chk(vram_we === 1'b0, "R5", int'(vram_we), 0);
    end
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    ix = tbl_idx(m_addr);
    if (code == 2'b11) begin
      if (!m_addr[0]) m_held = d;
      else begin
        model[ix - 6'd1] = m_held;
        model[ix]        = keep_low(d);
      end
    end
    m_addr = m_addr + 14'd1;
    chk(vram_addr === m_addr, "R6", int'(vram_addr), int'(m_addr));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    m_held = 8'h00;
    m_addr = 14'h0;

    // reset state: R1
    repeat (3) @(posedge clk);
    #1;
    chk(busy === 1'b1 && wr_ready === 1'b0, "R1", int'({busy, wr_ready}), 2);
    chk(vram_addr === 14'h0, "R1", int'(vram_addr), 0);

    // release reset with a video write already pending: R9 and R1 length
    @(negedge clk);
    rst = 1'b0;
    ctrl_code = 2'b00;
    wr_data = 8'h3C;
    wr_valid = 1'b1;
    n = 0;
    while (n < 200) begin
      @(posedge clk);
      n++;
      #1;
      if (!busy) break;
      chk(vram_we === 1'b0 && vram_addr === 14'h0, "R9",
          int'({vram_we, vram_addr}), 0);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    chk(n == 64, "R1", n, 64);
    chk(vram_addr === 14'h0, "R9", int'(vram_addr), 0);
    check_all("R1");

    // R8: odd write before any even write stores cleared holder
    set_addr(14'h0005);
    put(2'b11, 8'hAB);
    check_entry(4, "R8");
    check_entry(5, "R3");

    // R2 then R3
    put(2'b11, 8'h5A);
    check_all("R2");
    put(2'b11, 8'hF3);
    check_entry(6, "R3");
    check_entry(7, "R3");

    // R10: holder survives video write and reload
    put(2'b11, 8'h77);
    put(2'b01, 8'h99);
    check_all("R5");
    set_addr(14'h000B);
    put(2'b11, 8'hE6);
    check_entry(10, "R10");
    check_entry(11, "R10");

    // R4: high address maps modulo 64
    set_addr(14'h1234);
    put(2'b11, 8'h21);
    put(2'b11, 8'hCD);
    check_entry(52, "R4");
    check_entry(53, "R4");

    // R6 wrap
    set_addr(14'h3FFF);
    put(2'b10, 8'h11);
    chk(vram_addr === 14'h0, "R6", int'(vram_addr), 0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) set_addr(14'($urandom()));
      else if (r < 3) put(2'($urandom_range(0, 2)), 8'($urandom()));
      else put(2'b11, 8'($urandom()));
      if (k % 50 == 49) check_all("R3");
    end
    check_all("R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule